// File: doc/BRIEF.md
# Selector-Indexed Configuration Item Port

This block serves a fixed set of read-only configuration items to a host over a small memory-mapped slave. The host first writes a 16-bit selector that names one item. It then pulls that item's bytes out through an 8-byte data register, in accesses of 1, 2, 4 or 8 bytes. A hidden byte offset tracks how far into the current item the host has read. Every selector write sets that offset back to zero.

The items sit in a built-in store and are computed from parameters:
- a four-byte identification string;
- a feature word;
- one generic blob;
- one architecture-specific blob.

Any other selector value names an empty item. Reads that run past an item's end return zero bytes and do not wrap.

A three-state controller sequences each access:
- `ST_IDLE` accepts requests.
- `ST_GATHER` fetches one item byte per cycle into successive lanes.
- `ST_REPLY` presents the read result for one cycle.

The transitions are:
- `ST_IDLE`→`ST_GATHER` on a data-register read.
- `ST_IDLE`→`ST_REPLY` on a read of any other region.
- `ST_GATHER`→`ST_REPLY` once the last lane of the access is filled.
- `ST_REPLY`→`ST_IDLE` unconditionally.

Writes complete in `ST_IDLE` at the accepting edge and produce no response.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the selector is 0x0000, the offset is zero, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A write whose address has bits [4:3] = 01 updates the selector.
  - Lane 0 carries selector bits [15:8] and lane 1 carries bits [7:0] (big-endian).
  - Each lane is written only when its strobe bit is set.
  - Any such write resets the offset to zero.
- R3: The item is chosen by selector bit 15 (1 = architecture space) together with bits [13:0]. Bit 14 has no effect on which item is read.
- R4: A read of the data register (address bits [4:3] = 00) with `req_size` s returns N = 2^s bytes.
  - The bytes come from the current offset upward, with the lowest-offset byte in lane 0.
  - Lanes N..7 are zero.
  - The offset advances by N.
- R5: Item bytes at or beyond the item length read as 0x00. A read straddling the end returns the in-range bytes, and the offset saturates at the item length.
- R6: Writes to the data register are accepted but change neither the offset nor any item content, whatever selector bit 14 holds.
- R7: Generic index 0 is the four-byte signature. With the default parameter its bytes in order are 0x49, 0x43, 0x46, 0x47.
- R8: Generic index 1 is a 4-byte little-endian feature word. Bit 0 is 1, bit 1 equals `DMA_PRESENT` (default 1), and all other bits are 0. Its first byte is therefore 0x03 by default.
- R9: Generic index 2 holds `BLOB_LEN` (default 11) bytes, byte k = 0x A0 + k. Architecture index 5 holds `ARCH_LEN` (default 3) bytes, byte k = 0x51 + 2k. Every other key has length zero.
- R10: `req_ready` is 1 only in the idle state, and `rsp_valid` is a one-cycle pulse. A data read of N bytes accepted at edge E raises `rsp_valid` in the cycle after edge E+N.
- R11: A read of address bits [4:3] = 10 (DMA address region) or 11 returns zero in the cycle after acceptance and leaves the offset unchanged. Writes to these regions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte address within the 32-byte window |
| req_size | input | 2 | log2 of access width in bytes |
| req_wdata | input | 64 | Write data, lane k at bits [8k+7:8k] |
| req_wstrb | input | 8 | Per-lane write strobes |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 64 | Read data |

## Verification
The hardest situation to reach is a read that straddles the end of an item. Reaching it requires a particular sequence:
1. Select a short item.
2. Advance the offset to within fewer than N bytes of its end.
3. Issue a wide read.

That read must return partial data, after which the offset sits saturated. The stimulus reaches this case directly on the three-byte architecture item with two 2-byte reads. The random phase then mixes selector rewrites among all items, including bit-14 aliases and empty keys, with reads of every width. As a result, the offset meets item ends at many different alignments.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_REPLY  = 2'd2
    } port_state_e;

    typedef enum logic [1:0] {
        RG_DATA = 2'd0,
        RG_SEL  = 2'd1,
        RG_DMA  = 2'd2,
        RG_NONE = 2'd3
    } reg_region_e;

    typedef struct packed {
        logic        arch;
        logic [13:0] idx;
    } item_key_t;

    function automatic item_key_t key_of(input logic [15:0] sel);
        item_key_t k;
        k.arch = sel[15];
        k.idx  = sel[13:0];
        return k;
    endfunction

    function automatic logic [2:0] last_lane(input logic [1:0] size);
        logic [3:0] n;
        n = 4'd1 << size;
        return 3'(n - 4'd1);
    endfunction

endpackage

// File: rtl/cfgp_store.sv
module cfgp_store
    import cfgp_pkg::*;
#(
    parameter logic [31:0] SIG         = 32'h4943_4647,
    parameter bit          DMA_PRESENT = 1'b1,
    parameter int          BLOB_LEN    = 11,
    parameter int          ARCH_LEN    = 3,
    parameter int          OFF_W       = 8
) (
    input  item_key_t         key,
    input  logic [OFF_W-1:0]  off,
    output logic [OFF_W-1:0]  len,
    output logic [7:0]        raw_byte
);
    localparam logic [13:0] IDX_SIG  = 14'd0;
    localparam logic [13:0] IDX_FEAT = 14'd1;
    localparam logic [13:0] IDX_BLOB = 14'd2;
    localparam logic [13:0] IDX_ARCH = 14'd5;

    logic [7:0] feat_low;
    logic [7:0] off8;

    generate
        if (DMA_PRESENT) begin : g_feat_dma
            assign feat_low = 8'h03;
        end else begin : g_feat_plain
            assign feat_low = 8'h01;
        end
    endgenerate

    assign off8 = 8'(off);

    always_comb begin
        len      = '0;
        raw_byte = 8'h00;
        if (!key.arch) begin
            unique case (key.idx)
                IDX_SIG: begin
                    len = OFF_W'(4);
                    unique case (off[1:0])
                        2'd0: raw_byte = SIG[31:24];
                        2'd1: raw_byte = SIG[23:16];
                        2'd2: raw_byte = SIG[15:8];
                        default: raw_byte = SIG[7:0];
                    endcase
                end
                IDX_FEAT: begin
                    len      = OFF_W'(4);
                    raw_byte = (off == '0) ? feat_low : 8'h00;
                end
                IDX_BLOB: begin
                    len      = OFF_W'(BLOB_LEN);
                    raw_byte = 8'hA0 + off8;
                end
                default: ;
            endcase
        end else if (key.idx == IDX_ARCH) begin
            len      = OFF_W'(ARCH_LEN);
            raw_byte = 8'h51 + off8 + off8;
        end
    end

endmodule

// File: rtl/cfgp_selreg.sv
module cfgp_selreg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_lanes,
    input  logic [1:0]  wr_strb,
    output logic [15:0] sel
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= 16'h0000;
        end else if (wr_en) begin
            if (wr_strb[0]) sel[15:8] <= wr_lanes[7:0];
            if (wr_strb[1]) sel[7:0]  <= wr_lanes[15:8];
        end
    end
endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
    import cfgp_pkg::*;
#(
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [1:0]       region,
    input  logic [1:0]       req_size,
    output logic             rsp_valid,
    output logic [63:0]      rsp_rdata,
    output logic             sel_wr_en,
    input  logic [OFF_W-1:0] item_len,
    input  logic [7:0]       item_byte,
    output logic [OFF_W-1:0] cur_off
);
    port_state_e state_q, state_d;
    logic [OFF_W-1:0] off_q;
    logic [2:0]       lane_q;
    logic [2:0]       last_q;
    logic [63:0]      rdata_q;
    logic             accept;
    logic             in_range;

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign in_range = off_q < item_len;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !req_write)
                    state_d = (reg_region_e'(region) == RG_DATA) ? ST_GATHER : ST_REPLY;
            end
            ST_GATHER: begin
                if (lane_q == last_q) state_d = ST_REPLY;
            end
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_REPLY);
        rsp_rdata = rdata_q;
        sel_wr_en = accept && req_write && (reg_region_e'(region) == RG_SEL);
        cur_off   = off_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q   <= '0;
            lane_q  <= '0;
            last_q  <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sel_wr_en) off_q <= '0;
                    if (accept && !req_write) begin
                        rdata_q <= '0;
                        lane_q  <= '0;
                        last_q  <= last_lane(req_size);
                    end
                end
                ST_GATHER: begin
                    rdata_q[{lane_q, 3'b000} +: 8] <= in_range ? item_byte : 8'h00;
                    if (in_range) off_q <= off_q + 1'b1;
                    lane_q <= lane_q + 3'd1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
    import cfgp_pkg::*;
#(
    parameter logic [31:0] SIG         = 32'h4943_4647,
    parameter bit          DMA_PRESENT = 1'b1,
    parameter int          BLOB_LEN    = 11,
    parameter int          ARCH_LEN    = 3,
    parameter int          OFF_W       = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [4:0]  req_addr,
    input  logic [1:0]  req_size,
    input  logic [63:0] req_wdata,
    input  logic [7:0]  req_wstrb,
    output logic        rsp_valid,
    output logic [63:0] rsp_rdata
);
    logic [15:0]      sel;
    logic             sel_wr_en;
    logic [OFF_W-1:0] cur_off;
    logic [OFF_W-1:0] cur_len;
    logic [7:0]       item_byte;
    logic             unused_bits;

    assign unused_bits = ^{req_wdata[63:16], req_wstrb[7:2], req_addr[2:0]};

    cfgp_selreg u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sel_wr_en),
        .wr_lanes (req_wdata[15:0]),
        .wr_strb  (req_wstrb[1:0]),
        .sel      (sel)
    );

    cfgp_store #(
        .SIG(SIG), .DMA_PRESENT(DMA_PRESENT), .BLOB_LEN(BLOB_LEN),
        .ARCH_LEN(ARCH_LEN), .OFF_W(OFF_W)
    ) u_store (
        .key      (key_of(sel)),
        .off      (cur_off),
        .len      (cur_len),
        .raw_byte (item_byte)
    );

    cfgp_ctrl #(.OFF_W(OFF_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .region    (req_addr[4:3]),
        .req_size  (req_size),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .sel_wr_en (sel_wr_en),
        .item_len  (cur_len),
        .item_byte (item_byte),
        .cur_off   (cur_off)
    );

endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
    parameter int OFF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic [4:0]       req_addr,
    input logic [1:0]       req_size,
    input logic             rsp_valid,
    input logic [63:0]      rsp_rdata,
    input logic [OFF_W-1:0] cur_off,
    input logic [OFF_W-1:0] cur_len
);
    logic       acc;
    logic [1:0] lat_size;
    logic       lat_data;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_size <= 2'd0;
            lat_data <= 1'b0;
        end else if (acc && !req_write) begin
            lat_size <= req_size;
            lat_data <= (req_addr[4:3] == 2'b00);
        end
    end

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_sel_clears_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && req_addr[4:3] == 2'b01) |=> (cur_off == '0));

    p_off_saturates_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_off <= cur_len);

    p_data_write_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && req_addr[4:3] == 2'b00) |=> $stable(cur_off));

    p_other_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && req_addr[4:3] != 2'b00) |=> (rsp_valid && rsp_rdata == 64'd0));

    p_upper_lanes_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && lat_data) |-> ((rsp_rdata >> (7'd8 << lat_size)) == 64'd0));

endmodule

bind cfg_item_port cfg_item_port_chk #(.OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .cur_off   (cur_off),
    .cur_len   (cur_len)
);

// File: tb/cfg_item_port_tb.sv
module cfg_item_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_wstrb = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] m_sel = 16'h0000;
    int          m_off = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_item_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_wstrb(req_wstrb), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    function automatic int exp_len(input logic [15:0] s);
        if (!s[15] && s[13:0] == 14'd0) return 4;
        if (!s[15] && s[13:0] == 14'd1) return 4;
        if (!s[15] && s[13:0] == 14'd2) return 11;
        if ( s[15] && s[13:0] == 14'd5) return 3;
        return 0;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [15:0] s, input int k);
        logic [7:0] sig [4];
        sig[0] = 8'h49; sig[1] = 8'h43; sig[2] = 8'h46; sig[3] = 8'h47;
        if (k >= exp_len(s)) return 8'h00;
        if (!s[15] && s[13:0] == 14'd0) return sig[k];
        if (!s[15] && s[13:0] == 14'd1) return (k == 0) ? 8'h03 : 8'h00;
        if (!s[15]) return 8'(8'hA0 + k);
        return 8'(8'h51 + 2*k);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [63:0] d, input logic [7:0] s);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_size = 2'd3;
        req_wdata = d; req_wstrb = s;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [1:0] sz,
                            output logic [63:0] d, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        d = rsp_rdata;
    endtask

    task automatic sel_write(input logic [15:0] v, input logic [7:0] s, input string req);
        bus_write(5'd8, {48'h0, v[7:0], v[15:8]}, s);
        if (s[0]) m_sel[15:8] = v[15:8];
        if (s[1]) m_sel[7:0]  = v[7:0];
        m_off = 0;
    endtask

    task automatic data_read(input logic [1:0] sz, input string req);
        logic [63:0] got, exp;
        int lat, n;
        n = 1 << sz;
        exp = '0;
        for (int i = 0; i < n; i++) begin
            exp[8*i +: 8] = exp_byte(m_sel, m_off);
            if (m_off < exp_len(m_sel)) m_off++;
        end
        bus_read(5'd0, sz, got, lat);
        check(req, got, exp);
        check("R10 latency", 64'(lat), 64'(n + 1));
    endtask

    task automatic other_read(input logic [4:0] a, input string req);
        logic [63:0] got;
        int lat;
        bus_read(a, 2'd3, got, lat);
        check(req, got, 64'd0);
        check("R10/R11 latency", 64'(lat), 64'd1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] keys [8];
        void'($urandom(32'd20240611));
        keys[0] = 16'h0000; keys[1] = 16'h0001; keys[2] = 16'h0002; keys[3] = 16'h4002;
        keys[4] = 16'h8005; keys[5] = 16'hC005; keys[6] = 16'h0005; keys[7] = 16'h0010;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 ready after reset", 64'(req_ready), 64'd1);
        check("R1 no response after reset", 64'(rsp_valid), 64'd0);
        data_read(2'd2, "R1 R7 signature after reset");

        sel_write(16'h0001, 8'h03, "R2");
        data_read(2'd2, "R8 feature word");

        sel_write(16'h0000, 8'h03, "R2");
        data_read(2'd0, "R4 one byte");
        sel_write(16'h0000, 8'h03, "R2");
        data_read(2'd2, "R2 offset reset on select");

        // R2: only lane 1 strobed, lane 0 value must be dropped
        sel_write(16'hFF02, 8'h02, "R2");
        data_read(2'd3, "R2 partial strobe selects blob");
        data_read(2'd2, "R5 blob straddle");

        sel_write(16'h8005, 8'h03, "R2");
        data_read(2'd1, "R9 arch item head");
        data_read(2'd1, "R5 arch straddle");
        data_read(2'd3, "R5 arch past end");

        sel_write(16'h4002, 8'h03, "R2");
        data_read(2'd2, "R3 bit14 alias of blob");

        sel_write(16'h0002, 8'h03, "R2");
        data_read(2'd1, "R4 blob first two");
        bus_write(5'd0, 64'hDEAD_BEEF_0102_0304, 8'hFF);
        data_read(2'd1, "R6 data write no effect");
        sel_write(16'h4002, 8'h03, "R2");
        bus_write(5'd0, 64'h1111_1111_1111_1111, 8'hFF);
        data_read(2'd2, "R6 data write with bit14");

        sel_write(16'h0010, 8'h03, "R2");
        data_read(2'd3, "R9 unknown key zero");

        sel_write(16'h0002, 8'h03, "R2");
        data_read(2'd0, "R4");
        other_read(5'd16, "R11 DMA region read zero");
        other_read(5'd24, "R11 unused region read zero");
        other_read(5'd8, "R11 selector read zero");
        bus_write(5'd16, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
        data_read(2'd2, "R11 DMA write ignored");

        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 2) sel_write(keys[$urandom_range(0, 7)], 8'h03, "R2 random");
            else if (op < 8) data_read(2'($urandom_range(0, 3)), "R4 R5 random read");
            else if (op == 8) bus_write(5'd0, {$urandom, $urandom}, 8'hFF);
            else other_read(5'd16, "R11 random");
        end

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule